// File: doc/BRIEF.md
# Fractional Accumulator ALU with Clipping Barrel Shifter

This block is the arithmetic execution path of a small audio signal processor with a 20-bit accumulator. It takes the low 15 bits of an arithmetic instruction word. It collects the 16-bit operands that the instruction needs through a request/valid handshake. From these it builds two ALU inputs: the accumulator, an operand placed in bits 19:4, or a fractional product from a signed 16x16 multiplier. It runs one of sixteen ALU operations and derives five condition flags. It then passes the result through a barrel shifter whose amounts come from a fixed non-linear table, and whose largest left setting clips and saturates instead of shifting.

When the instruction finishes, the shifted value becomes the new accumulator and the flags are registered. A store request tells the surrounding sequencer whether the top 16 bits of the accumulator go to a pending write-back address or to the next operand slot that was not consumed. Operand address generation, instruction fetch and branching belong to the sequencer and are not part of this block.

Top module: `acc_alu_unit`

## Requirements
- R1: After synchronous reset the accumulator and flags read zero, and `busy`, `done`, `op_req` and `store_valid` are low.
- R2: Operands are requested one at a time, in a fixed order: first multiplier input, second multiplier input, A operand, B operand, shift-amount operand. An item is requested only when the instruction uses it. `op_req` falls once all are received.
- R3: Field layout: bits 14:13 give the operand count, bit 12 the multiplier second-input select, bits 11:10 the A source and bits 9:8 the B source. Bits 7:4 give the ALU code and bits 3:0 the shift code. For a source, 0 selects the accumulator as it was before the instruction, 1 or 2 select an operand shifted left by 4, and 3 selects the multiplier.
- R4: The multiplier multiplies two signed 16-bit values. The first is an operand. The second is an operand when bit 12 is 1, and accumulator bits 19:4 otherwise. The product is arithmetically shifted right by 11 and its low 20 bits are used. The multiplier consumes operands only when a source selects it.
- R5: ALU codes: 0 pass A, 1 negate B, 2 A+B, 3 A plus carry, 4 A-B, 5 A minus borrow, 6 A+1, 7 A-1, 8 logical pass A, 9 NOT A, 10 AND, 11 NAND, 12 OR, 13 NOR, 14 XOR, 15 XNOR.
- R6: The `flags` output is {N,Z,X,V,C} from bit 4 down to bit 0. N is result bit 19. Z is set when bits 19:4 are all zero. X is set when bits 3:0 are all zero. C is bit 20 of the unsigned 21-bit sum or difference for codes 2 to 5, and is 0 for all other codes. V is a signed overflow for codes 2, 4, 6 and 7 (with an increment only overflowing from positive to negative, and a decrement only from negative to positive), and is 0 for all other codes.
- R7: Codes 3 and 5 add or subtract 16, one unit in bit 4, when the carry flag left by the previous instruction is set.
- R8: A shift code with bit 3 clear shifts left by table[code]. A code with bit 3 set shifts right by table[(-code) mod 8]. The table is {0,1,2,3,4,5,8,16}. A shift code of 8 takes the real code from bits 3:0 of an extra operand.
- R9: Right shifts are arithmetic for ALU codes 0 to 7 and logical on the 20-bit value for codes 8 to 15.
- R10: A left shift of 16 clips. If V is set, the accumulator becomes 0x7FFFF when N is set, and 0x80000 when N is clear. If V is clear, the unshifted result is kept.
- R11: A store request carries accumulator bits 19:4. With a pending write-back it goes to the write-back target (`store_wb`=1). Otherwise it goes to the slot whose index equals the number of operands consumed, provided that index is below the effective operand count. The effective count is the field value, replaced by 4 when the field is 0 and A or B reads an operand, plus 1 when the shift code is 8. Otherwise no store is made.
- R12: `done` pulses for exactly one cycle per instruction. The accumulator and flags change only in that completion step and hold while operands are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| arith_word | input | 15 | Instruction bits 14:0 |
| wb_set | input | 1 | A write-back target is pending for this instruction |
| busy | output | 1 | An instruction is in progress |
| op_req | output | 1 | Next operand wanted |
| op_valid | input | 1 | Operand on op_data is valid |
| op_data | input | 16 | Operand value |
| done | output | 1 | Instruction completed this cycle |
| acc | output | 20 | Accumulator |
| flags | output | 5 | {N,Z,X,V,C} |
| store_valid | output | 1 | Store request present |
| store_wb | output | 1 | 1: to write-back target, 0: to operand slot |
| store_slot | output | 3 | Operand slot index for a slot store |
| store_data | output | 16 | Accumulator bits 19:4 |

## Verification
The assertions assume that `op_valid` is raised only while `op_req` is high, and that `start` arrives only while `busy` is low. Without these, the operand counter and the completion pulse could advance outside the collection phase. The bench keeps to this: it drives an operand only on a falling edge where it sees `op_req`, and it begins each instruction only after the previous `done`. Expected values come from a separate reference model and from hand-worked saturation, shift and store cases.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OPND_W  = 16;
    localparam int FRAC_W  = 4;
    localparam int DATA_W  = OPND_W + FRAC_W;
    localparam int SHC_W   = 4;
    localparam int MAX_OPS = 4;
    localparam int IDX_W   = $clog2(MAX_OPS);
    localparam int CNT_W   = IDX_W + 1;
    localparam int MUL_SHR = 11;

    localparam logic [DATA_W-1:0] FULL_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] FULL_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [1:0] {
        SRC_ACC = 2'd0,
        SRC_OP1 = 2'd1,
        SRC_OP2 = 2'd2,
        SRC_MUL = 2'd3
    } src_e;

    typedef enum logic [3:0] {
        ALU_PASS = 4'd0,  ALU_NEG  = 4'd1,  ALU_ADD  = 4'd2,  ALU_ADC  = 4'd3,
        ALU_SUB  = 4'd4,  ALU_SBB  = 4'd5,  ALU_INC  = 4'd6,  ALU_DEC  = 4'd7,
        ALU_LPAS = 4'd8,  ALU_NOT  = 4'd9,  ALU_AND  = 4'd10, ALU_NAND = 4'd11,
        ALU_OR   = 4'd12, ALU_NOR  = 4'd13, ALU_XOR  = 4'd14, ALU_XNOR = 4'd15
    } alu_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic x;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [1:0]       cnt;
        logic             mul2;
        src_e             mux_a;
        src_e             mux_b;
        alu_e             op;
        logic [SHC_W-1:0] shc;
    } ifields_t;

    function automatic logic [4:0] shift_amt(input logic [2:0] i);
        case (i)
            3'd6:    return 5'd8;
            3'd7:    return 5'd16;
            default: return {2'b00, i};
        endcase
    endfunction

    function automatic logic reads_operand(input src_e s);
        return (s == SRC_OP1) || (s == SRC_OP2);
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [1:0]       cnt_fld,
    input  logic             mul2,
    input  src_e             mux_a,
    input  src_e             mux_b,
    input  logic [SHC_W-1:0] shc,
    output logic             mul_used,
    output logic [IDX_W-1:0] idx_m1,
    output logic [IDX_W-1:0] idx_m2,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b,
    output logic [IDX_W-1:0] idx_s,
    output logic [CNT_W-1:0] need,
    output logic [CNT_W-1:0] numops
);
    logic [CNT_W-1:0] p;

    // R2: slots are allocated in consumption order
    always_comb begin
        p      = '0;
        idx_m1 = '0;
        idx_m2 = '0;
        idx_a  = '0;
        idx_b  = '0;
        idx_s  = '0;
        mul_used = (mux_a == SRC_MUL) || (mux_b == SRC_MUL);
        if (mul_used) begin
            idx_m1 = p[IDX_W-1:0];
            p      = p + 1'b1;
            if (mul2) begin
                idx_m2 = p[IDX_W-1:0];
                p      = p + 1'b1;
            end
        end
        if (reads_operand(mux_a)) begin
            idx_a = p[IDX_W-1:0];
            p     = p + 1'b1;
        end
        if (reads_operand(mux_b)) begin
            idx_b = p[IDX_W-1:0];
            p     = p + 1'b1;
        end
        if (shc == SHC_W'(8)) begin
            idx_s = p[IDX_W-1:0];
            p     = p + 1'b1;
        end
        need = p;
    end

    // R11: effective operand count
    always_comb begin
        numops = CNT_W'(cnt_fld);
        if (cnt_fld == 2'd0 && (reads_operand(mux_a) || reads_operand(mux_b)))
            numops = CNT_W'(MAX_OPS);
        if (shc == SHC_W'(8))
            numops = numops + 1'b1;
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_e              op,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output flags_t            fl
);
    localparam logic [DATA_W:0] UNIT = (DATA_W+1)'(1) << FRAC_W;

    logic [DATA_W:0] wide;
    logic            c_out;
    logic            v_out;

    always_comb begin
        wide  = '0;
        res   = '0;
        c_out = 1'b0;
        v_out = 1'b0;
        case (op)
            ALU_PASS: res = a;
            ALU_NEG:  res = -b;
            ALU_ADD: begin
                wide  = {1'b0, a} + {1'b0, b};
                res   = wide[DATA_W-1:0];
                c_out = wide[DATA_W];
                v_out = (a[DATA_W-1] == b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
            end
            ALU_ADC: begin
                wide  = {1'b0, a} + (cin ? UNIT : '0);
                res   = wide[DATA_W-1:0];
                c_out = wide[DATA_W];
            end
            ALU_SUB: begin
                wide  = {1'b0, a} - {1'b0, b};
                res   = wide[DATA_W-1:0];
                c_out = wide[DATA_W];
                v_out = (a[DATA_W-1] != b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
            end
            ALU_SBB: begin
                wide  = {1'b0, a} - (cin ? UNIT : '0);
                res   = wide[DATA_W-1:0];
                c_out = wide[DATA_W];
            end
            ALU_INC: begin
                res   = a + 1'b1;
                v_out = !a[DATA_W-1] && res[DATA_W-1];
            end
            ALU_DEC: begin
                res   = a - 1'b1;
                v_out = a[DATA_W-1] && !res[DATA_W-1];
            end
            ALU_LPAS: res = a;
            ALU_NOT:  res = ~a;
            ALU_AND:  res = a & b;
            ALU_NAND: res = ~(a & b);
            ALU_OR:   res = a | b;
            ALU_NOR:  res = ~(a | b);
            ALU_XOR:  res = a ^ b;
            ALU_XNOR: res = ~(a ^ b);
            default:  res = a;
        endcase
        // R6: flag derivation
        fl.n = res[DATA_W-1];
        fl.z = (res[DATA_W-1:FRAC_W] == '0);
        fl.x = (res[FRAC_W-1:0] == '0);
        fl.v = v_out;
        fl.c = c_out;
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic [SHC_W-1:0]  code,
    input  logic              logical,
    input  logic              ovf,
    input  logic              neg,
    output logic [DATA_W-1:0] out
);
    logic [4:0] amt;

    always_comb begin
        if (code[SHC_W-1]) begin
            // R8/R9: right shift indexed by the negated code
            amt = shift_amt(3'(~code[2:0] + 3'd1));
            if (logical)
                out = val >> amt;
            else
                out = DATA_W'($signed(val) >>> amt);
        end else begin
            amt = shift_amt(code[2:0]);
            if (amt == 5'd16) begin
                // R10: clip instead of shifting
                if (ovf)
                    out = neg ? FULL_POS : FULL_NEG;
                else
                    out = val;
            end else begin
                out = DATA_W'(val << amt);
            end
        end
    end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [14:0]       arith_word,
    input  logic              wb_set,
    output logic              busy,
    output logic              op_req,
    input  logic              op_valid,
    input  logic [15:0]       op_data,
    output logic              done,
    output logic [19:0]       acc,
    output logic [4:0]        flags,
    output logic              store_valid,
    output logic              store_wb,
    output logic [2:0]        store_slot,
    output logic [15:0]       store_data
);
    state_e            state_q;
    ifields_t          fld;
    logic              wb_q;
    logic [OPND_W-1:0] opnd_q [MAX_OPS];
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    flags_t            flg_q;
    logic              done_q;
    logic              st_valid_q;
    logic              st_wb_q;
    logic [CNT_W-1:0]  st_slot_q;

    logic              mul_used;
    logic [IDX_W-1:0]  idx_m1, idx_m2, idx_a, idx_b, idx_s;
    logic [CNT_W-1:0]  need;
    logic [CNT_W-1:0]  numops;

    acc_alu_decode u_dec (
        .cnt_fld  (fld.cnt),
        .mul2     (fld.mul2),
        .mux_a    (fld.mux_a),
        .mux_b    (fld.mux_b),
        .shc      (fld.shc),
        .mul_used (mul_used),
        .idx_m1   (idx_m1),
        .idx_m2   (idx_m2),
        .idx_a    (idx_a),
        .idx_b    (idx_b),
        .idx_s    (idx_s),
        .need     (need),
        .numops   (numops)
    );

    // R4: fractional multiplier
    logic signed [OPND_W-1:0]   mul_x;
    logic signed [OPND_W-1:0]   mul_y;
    logic signed [2*OPND_W-1:0] prod;
    logic [DATA_W-1:0]          mul_res;

    always_comb begin
        mul_x = mul_used ? $signed(opnd_q[idx_m1]) : '0;
        mul_y = fld.mul2 ? $signed(opnd_q[idx_m2]) : $signed(acc_q[DATA_W-1:FRAC_W]);
        prod  = mul_x * mul_y;
        mul_res = DATA_W'(prod >>> MUL_SHR);
    end

    // R3: input source selection
    logic [DATA_W-1:0] a_val;
    logic [DATA_W-1:0] b_val;

    always_comb begin
        case (fld.mux_a)
            SRC_ACC: a_val = acc_q;
            SRC_MUL: a_val = mul_res;
            default: a_val = {opnd_q[idx_a], {FRAC_W{1'b0}}};
        endcase
        case (fld.mux_b)
            SRC_ACC: b_val = acc_q;
            SRC_MUL: b_val = mul_res;
            default: b_val = {opnd_q[idx_b], {FRAC_W{1'b0}}};
        endcase
    end

    logic [DATA_W-1:0] alu_res;
    flags_t            alu_fl;

    acc_alu_core u_alu (
        .a   (a_val),
        .b   (b_val),
        .op  (fld.op),
        .cin (flg_q.c),
        .res (alu_res),
        .fl  (alu_fl)
    );

    logic [SHC_W-1:0]  sh_code;
    logic [DATA_W-1:0] sh_out;

    assign sh_code = (fld.shc == SHC_W'(8)) ? opnd_q[idx_s][SHC_W-1:0] : fld.shc;

    acc_alu_shift u_shf (
        .val     (alu_res),
        .code    (sh_code),
        .logical (fld.op[3]),
        .ovf     (alu_fl.v),
        .neg     (alu_fl.n),
        .out     (sh_out)
    );

    // Sequencer: collect operands, then complete in one step
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            fld        <= '0;
            wb_q       <= 1'b0;
            cnt_q      <= '0;
            acc_q      <= '0;
            flg_q      <= '0;
            done_q     <= 1'b0;
            st_valid_q <= 1'b0;
            st_wb_q    <= 1'b0;
            st_slot_q  <= '0;
            for (int i = 0; i < MAX_OPS; i++) opnd_q[i] <= '0;
        end else begin
            done_q     <= 1'b0;
            st_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fld     <= ifields_t'(arith_word);
                        wb_q    <= wb_set;
                        cnt_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (cnt_q == need) begin
                        state_q <= ST_EXEC;
                    end else if (op_valid) begin
                        opnd_q[cnt_q[IDX_W-1:0]] <= op_data;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EXEC: begin
                    acc_q   <= sh_out;
                    flg_q   <= alu_fl;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    // R11: store routing
                    if (wb_q) begin
                        st_valid_q <= 1'b1;
                        st_wb_q    <= 1'b1;
                        st_slot_q  <= '0;
                    end else if (cnt_q < numops) begin
                        st_valid_q <= 1'b1;
                        st_wb_q    <= 1'b0;
                        st_slot_q  <= cnt_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign op_req      = (state_q == ST_FETCH) && (cnt_q != need);
    assign done        = done_q;
    assign acc         = acc_q;
    assign flags       = flg_q;
    assign store_valid = st_valid_q;
    assign store_wb    = st_wb_q;
    assign store_slot  = st_slot_q;
    assign store_data  = acc_q[DATA_W-1:FRAC_W];

    // Assertions
    a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_valid) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |-> (cnt_q <= need));

    a_r12_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_EXEC) |=> ($stable(acc_q) && $stable(flg_q)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    a_r10_clip_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && sh_code == 4'd7 && alu_fl.v)
        |=> (acc_q == FULL_POS || acc_q == FULL_NEG));

    a_r11_store_at_done: assert property (@(posedge clk) disable iff (rst)
        st_valid_q |-> done_q);

endmodule

// File: tb/sim_acc_alu_unit.sv
module sim_acc_alu_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [14:0] arith_word = '0;
    logic        wb_set = 1'b0;
    logic        busy;
    logic        op_req;
    logic        op_valid = 1'b0;
    logic [15:0] op_data = '0;
    logic        done;
    logic [19:0] acc;
    logic [4:0]  flags;
    logic        store_valid;
    logic        store_wb;
    logic [2:0]  store_slot;
    logic [15:0] store_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_alu_unit u0 (
        .clk(clk), .rst(rst), .start(start), .arith_word(arith_word),
        .wb_set(wb_set), .busy(busy), .op_req(op_req), .op_valid(op_valid),
        .op_data(op_data), .done(done), .acc(acc), .flags(flags),
        .store_valid(store_valid), .store_wb(store_wb),
        .store_slot(store_slot), .store_data(store_data)
    );

    // {word, wb, op0, op1, op2, op3}
    localparam int NV = 17;
    localparam logic [79:0] VECS [NV] = '{
        {15'h2400, 1'b0, 16'h1234, 16'h0000, 16'h0000, 16'h0000},
        {15'h2121, 1'b0, 16'h0F00, 16'h0000, 16'h0000, 16'h0000},
        {15'h4440, 1'b0, 16'h0100, 16'h0000, 16'h0000, 16'h0000},
        {15'h0030, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {15'h0C20, 1'b0, 16'h7000, 16'h0000, 16'h0000, 16'h0000},
        {15'h1C00, 1'b0, 16'h4000, 16'h2000, 16'h0000, 16'h0000},
        {15'h06A0, 1'b0, 16'hF0F0, 16'h3C3C, 16'h0000, 16'h0000},
        {15'h45F8, 1'b0, 16'h1111, 16'h2222, 16'h000D, 16'h0000},
        {15'h2110, 1'b1, 16'h0010, 16'h0000, 16'h0000, 16'h0000},
        {15'h0062, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {15'h007F, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {15'h21DE, 1'b0, 16'h5555, 16'h0000, 16'h0000, 16'h0000},
        {15'h2454, 1'b0, 16'h0001, 16'h0000, 16'h0000, 16'h0000},
        {15'h21C7, 1'b0, 16'h8000, 16'h0000, 16'h0000, 16'h0000},
        {15'h21B6, 1'b0, 16'h00FF, 16'h0000, 16'h0000, 16'h0000},
        {15'h1C80, 1'b0, 16'h8000, 16'h8000, 16'h0000, 16'h0000},
        {15'h0095, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [14:0] w, input logic wb,
                          input logic [15:0] o0, input logic [15:0] o1,
                          input logic [15:0] o2, input logic [15:0] o3,
                          output int nreq);
        logic [15:0] ol [4];
        int k;
        ol = '{o0, o1, o2, o3};
        k = 0;
        @(negedge clk);
        start = 1'b1; arith_word = w; wb_set = wb;
        @(negedge clk);
        start = 1'b0; wb_set = 1'b0;
        while (!done) begin
            if (op_req && k < 4) begin
                op_valid = 1'b1;
                op_data  = ol[k];
                k++;
            end else begin
                op_valid = 1'b0;
            end
            @(negedge clk);
        end
        op_valid = 1'b0;
        nreq = k;
    endtask

    // Independent reference of R2..R11
    function automatic void ref_step(
        input logic [14:0] w, input logic wb, input logic [15:0] o [4],
        input logic [19:0] ain, input logic cin,
        output logic [19:0] aout, output logic [4:0] fo,
        output logic sv, output logic swb, output logic [2:0] sl,
        output logic cout, output int used);
        int k, ma, mb, opc, sc, nops, av, bv, r, mv, sh;
        int tbl [8];
        logic m2, c, v;
        logic [19:0] r20;
        longint p;
        tbl = '{0, 1, 2, 3, 4, 5, 8, 16};
        k = 0; nops = int'(w[14:13]); m2 = w[12];
        ma = int'(w[11:10]); mb = int'(w[9:8]); opc = int'(w[7:4]); sc = int'(w[3:0]);
        mv = 0; av = 0; bv = 0; r = 0; c = 1'b0; v = 1'b0;
        if (ma == 3 || mb == 3) begin
            if (m2) p = longint'($signed(o[k])) * longint'($signed(o[k+1]));
            else    p = longint'($signed(o[k])) * longint'($signed(ain[19:4]));
            k = k + (m2 ? 2 : 1);
            mv = int'((p >>> 11) & 64'hFFFFF);
        end
        if (ma == 0) av = int'(ain);
        else if (ma == 3) av = mv;
        else begin av = int'({o[k], 4'h0}); k++; end
        if (mb == 0) bv = int'(ain);
        else if (mb == 3) bv = mv;
        else begin bv = int'({o[k], 4'h0}); k++; end
        if (nops == 0 && (ma == 1 || ma == 2 || mb == 1 || mb == 2)) nops = 4;
        if (sc == 8) begin nops++; sc = int'(o[k][3:0]); k++; end
        case (opc)
            0, 8: r = av;
            1: r = -bv;
            2: begin r = av + bv; c = r[20];
                 v = (av[19] == bv[19]) && (r[19] != av[19]); end
            3: begin r = av + (cin ? 16 : 0); c = r[20]; end
            4: begin r = av - bv; c = r[20];
                 v = (av[19] != bv[19]) && (r[19] != av[19]); end
            5: begin r = av - (cin ? 16 : 0); c = r[20]; end
            6: begin r = av + 1; v = !av[19] && r[19]; end
            7: begin r = av - 1; v = av[19] && !r[19]; end
            9: r = ~av;
            10: r = av & bv;
            11: r = ~(av & bv);
            12: r = av | bv;
            13: r = ~(av | bv);
            14: r = av ^ bv;
            default: r = ~(av ^ bv);
        endcase
        r20 = r[19:0];
        fo = {r20[19], r20[19:4] == 16'h0, r20[3:0] == 4'h0, v, c};
        if (sc >= 8) begin
            sh = tbl[(16 - sc) & 7];
            if (opc < 8) aout = 20'($signed(r20) >>> sh);
            else         aout = r20 >> sh;
        end else if (tbl[sc] == 16) begin
            aout = v ? (r20[19] ? 20'h7FFFF : 20'h80000) : r20;
        end else begin
            aout = 20'(r20 << tbl[sc]);
        end
        sv = 1'b0; swb = 1'b0; sl = '0;
        if (wb) begin sv = 1'b1; swb = 1'b1; end
        else if (k < nops) begin sv = 1'b1; sl = 3'(k); end
        cout = c;
        used = k;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] acc_m, e_acc;
        logic [4:0]  e_fl;
        logic        c_m, e_sv, e_wb, e_c;
        logic [2:0]  e_sl;
        logic [15:0] ops [4];
        logic [79:0] ve;
        int nreq, used;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "acc", 32'(acc), 0);
        chk("R1", "flags", 32'(flags), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "op_req", 32'(op_req), 0);
        chk("R1", "store_valid", 32'(store_valid), 0);

        // Table walk against the reference (R3 R4 R5 R6 R7 R8 R9 R11)
        acc_m = '0; c_m = 1'b0;
        for (int i = 0; i < NV; i++) begin
            ve  = VECS[i];
            ops = '{ve[63:48], ve[47:32], ve[31:16], ve[15:0]};
            ref_step(ve[79:65], ve[64], ops, acc_m, c_m, e_acc, e_fl, e_sv, e_wb, e_sl, e_c, used);
            run_op(ve[79:65], ve[64], ops[0], ops[1], ops[2], ops[3], nreq);
            chk("R2", $sformatf("vec%0d operands", i), 32'(nreq), 32'(used));
            chk("R5", $sformatf("vec%0d acc", i), 32'(acc), 32'(e_acc));
            chk("R6", $sformatf("vec%0d flags", i), 32'(flags), 32'(e_fl));
            chk("R11", $sformatf("vec%0d store_valid", i), 32'(store_valid), 32'(e_sv));
            if (e_sv) begin
                chk("R11", $sformatf("vec%0d store_wb", i), 32'(store_wb), 32'(e_wb));
                chk("R11", $sformatf("vec%0d store_slot", i), 32'(store_slot), 32'(e_sl));
                chk("R11", $sformatf("vec%0d store_data", i), 32'(store_data), 32'(e_acc[19:4]));
            end
            acc_m = e_acc; c_m = e_c;
            @(negedge clk);
            chk("R12", $sformatf("vec%0d done one cycle", i), 32'(done), 0);
        end

        // R10: positive overflow clips to 0x7FFFF
        run_op(15'h2400, 1'b0, 16'h7FFF, 0, 0, 0, nreq);
        run_op(15'h2127, 1'b0, 16'h0001, 0, 0, 0, nreq);
        chk("R10", "pos clip acc", 32'(acc), 32'h7FFFF);
        chk("R6", "pos clip flags", 32'(flags), 32'h16);

        // R10: negative overflow clips to 0x80000
        run_op(15'h2400, 1'b0, 16'h8000, 0, 0, 0, nreq);
        run_op(15'h2127, 1'b0, 16'hFFFF, 0, 0, 0, nreq);
        chk("R10", "neg clip acc", 32'(acc), 32'h80000);
        chk("R6", "neg clip flags", 32'(flags), 32'h07);

        // R7: carry left by the previous instruction is added in units of 16
        run_op(15'h0030, 1'b0, 0, 0, 0, 0, nreq);
        chk("R7", "add carry acc", 32'(acc), 32'h80010);

        // R9: arithmetic versus logical right shift by 1
        run_op(15'h2400, 1'b0, 16'h8000, 0, 0, 0, nreq);
        run_op(15'h000F, 1'b0, 0, 0, 0, 0, nreq);
        chk("R9", "arith right", 32'(acc), 32'hC0000);
        run_op(15'h2400, 1'b0, 16'h8000, 0, 0, 0, nreq);
        run_op(15'h008F, 1'b0, 0, 0, 0, 0, nreq);
        chk("R9", "logical right", 32'(acc), 32'h40000);

        // R11: count field 0 with an operand source behaves as 4
        run_op(15'h0400, 1'b0, 16'h0003, 0, 0, 0, nreq);
        chk("R2", "one operand", 32'(nreq), 1);
        chk("R11", "slot store valid", 32'(store_valid), 1);
        chk("R11", "slot store target", 32'(store_wb), 0);
        chk("R11", "slot index", 32'(store_slot), 1);
        chk("R11", "slot data", 32'(store_data), 32'h0003);

        // R11: all slots consumed, no store; write-back wins
        run_op(15'h2400, 1'b0, 16'h00AB, 0, 0, 0, nreq);
        chk("R11", "no store", 32'(store_valid), 0);
        run_op(15'h2400, 1'b1, 16'h00AB, 0, 0, 0, nreq);
        chk("R11", "wb store", 32'(store_wb), 1);
        chk("R11", "wb data", 32'(store_data), 32'h00AB);

        // R8: shift amount from an extra operand, code 6 = left by 8
        run_op(15'h2408, 1'b0, 16'h0001, 16'h0006, 0, 0, nreq);
        chk("R2", "shift operand fetched", 32'(nreq), 2);
        chk("R8", "left 8 via operand", 32'(acc), 32'h01000);

        // R4: multiplier with the accumulator as second input
        run_op(15'h2400, 1'b0, 16'h4000, 0, 0, 0, nreq);
        run_op(15'h0C00, 1'b0, 16'h4000, 0, 0, 0, nreq);
        chk("R4", "mul by acc", 32'(acc), 32'h20000);

        // R3/R12: accumulator and flags hold while operands are outstanding
        @(negedge clk);
        start = 1'b1; arith_word = 15'h2400; wb_set = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R12", "acc held in fetch", 32'(acc), 32'h20000);
            chk("R12", "no done in fetch", 32'(done), 0);
            chk("R2", "request pending", 32'(op_req), 1);
        end
        op_valid = 1'b1; op_data = 16'h0042;
        @(negedge clk);
        op_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R3", "operand justified", 32'(acc), 32'h00420);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule